// File: doc/BRIEF.md
# Trace Enable Start/Stop Controller

This block decides on every clock cycle whether instruction tracing is switched on. A one-bit start/stop state sits between the comparator match inputs and the trace-enable output. Each comparator input can be chosen as a start source, as a stop source, or as both. A start source acts when its input is high. A stop source acts when its input is low. The two external trigger inputs never change this state.

A programmable event code must also evaluate true before tracing is enabled. One reserved code makes the event always true. Any other code picks a single comparator input or external input, and the event follows that input. A control bit decides whether the start/stop state also gates tracing. The three configuration registers are loaded through a simple write port. The trace-enable output is registered. The start/stop state is also brought out so that other resource logic can use it.

Top module: `trace_enable_ctl`

## Requirements
- R1: While `rst_n` is low, both `ss_state` and `trace_en` are 0 on the next clock edge. After reset every configuration field is zero. Event code 0 selects comparator 0, so once reset is released `trace_en` follows `cmp_match[0]` one cycle later.
- R2: If any comparator input is high and its bit is set in the start mask, `ss_state` is 1 after the next edge. The start mask is bits [NUM_CMP-1:0] of register address 2.
- R3: If no start condition is present, and any comparator input is low while its bit is set in the stop mask, `ss_state` is 0 after the next edge. The stop mask is bits [16+NUM_CMP-1:16] of register address 2.
- R4: If a start condition and a stop condition occur in the same cycle, `ss_state` becomes 1.
- R5: With neither a start condition nor a stop condition, `ss_state` holds its value. `ext_trig` has no effect on `ss_state`.
- R6: When bit 25 of register address 0 is 1, `trace_en` is 1 only if the start/stop state taken on that same edge is 1. When the bit is 0, the start/stop state has no effect on `trace_en`.
- R7: Event code 0x6F (bits [6:0] of register address 1) makes the event always true.
- R8: For any other code, the event works as follows. If code bit 2 is 0, the event equals `cmp_match[code[1:0]]`, and it is false when that index is NUM_CMP or higher. If code bit 2 is 1, the event equals `ext_trig[code[0]]`. Code bits [6:3] are ignored.
- R9: `trace_en` is registered. It equals event AND (NOT gate OR next start/stop state), evaluated on the inputs present before the edge. It changes exactly one cycle after the inputs that cause the change.
- R10: A write with `wr_en` high takes effect from the edge on which it is sampled, so it first affects outputs one edge later. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 event, 2 masks |
| wr_data | input | 32 | Write data |
| cmp_match | input | NUM_CMP | Comparator match inputs |
| ext_trig | input | 2 | External trigger inputs |
| ss_state | output | 1 | Start/stop state, 1 = start |
| trace_en | output | 1 | Registered trace enable |

## Verification
On every cycle, the assertions check the following behaviours:
- a selected start input forces the start state, and it wins over a stop condition;
- a stop condition alone clears the state;
- an idle cycle leaves the state unchanged;
- a gated enable never occurs while the state is stop;
- the always-true code with gating off yields an enable on the next cycle;
- reset clears both outputs.

Only the bench's sweeps show the rest. These are the exact routing of each event code to one comparator or external input, the indifference to upper code bits and to address-3 writes, and the one-cycle timing of register writes against the output.

// File: rtl/tecfg_pkg.sv
// Package: shared constants for the trace enable start/stop controller.
// Assumes a 32-bit write data path and a 7-bit event code field.
package tecfg_pkg;
    localparam int CODE_W    = 7;
    localparam int GATE_BIT  = 25;
    localparam int STOP_LSB  = 16;
    localparam logic [CODE_W-1:0] EV_ALWAYS = 7'h6F;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_EVENT = 2'd1,
        REG_MASK  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tecfg_regs.sv
// Module: configuration registers loaded from a simple write port.
// Holds the gate control bit, the event code and the start/stop masks.
// Assumes the write data is at least STOP_LSB+NUM_CMP bits wide. Address 3 is ignored.
module tecfg_regs
    import tecfg_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              gate_en,
    output logic [CODE_W-1:0] ev_code,
    output logic [NUM_CMP-1:0] start_mask,
    output logic [NUM_CMP-1:0] stop_mask
);
    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    // Capture register writes; all fields clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_en    <= 1'b0;
            ev_code    <= '0;
            start_mask <= '0;
            stop_mask  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_CTRL:  gate_en <= wr_data[GATE_BIT];
                REG_EVENT: ev_code <= wr_data[CODE_W-1:0];
                REG_MASK: begin
                    start_mask <= wr_data[NUM_CMP-1:0];
                    stop_mask  <= wr_data[STOP_LSB +: NUM_CMP];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tecfg_ss.sv
// Module: one-bit start/stop state driven by mask-selected comparator inputs.
// A start input acts when high, and a stop input acts when low. Start wins over stop.
// Assumes the comparator inputs are synchronous to clk.
module tecfg_ss #(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_match,
    input  logic [NUM_CMP-1:0] start_mask,
    input  logic [NUM_CMP-1:0] stop_mask,
    output logic               ss_next,
    output logic               ss_q
);
    logic [NUM_CMP-1:0] start_vec;
    logic [NUM_CMP-1:0] stop_vec;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_src
        assign start_vec[i] = start_mask[i] & cmp_match[i];
        assign stop_vec[i]  = stop_mask[i] & ~cmp_match[i];
    end

    // Next state: start has priority, then stop, otherwise hold.
    always_comb begin
        if (|start_vec)     ss_next = 1'b1;
        else if (|stop_vec) ss_next = 1'b0;
        else                ss_next = ss_q;
    end

    // State register, reset to stop.
    always_ff @(posedge clk) begin
        if (!rst_n) ss_q <= 1'b0;
        else        ss_q <= ss_next;
    end
endmodule

// File: rtl/tecfg_event.sv
// Module: trace-enable event evaluation.
// The reserved code gives true. Otherwise code bit 2 picks the comparator group or the
// external group, and the low bits pick the input. Out-of-range comparators give false.
module tecfg_event
    import tecfg_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic [CODE_W-1:0]  ev_code,
    input  logic [NUM_CMP-1:0] cmp_match,
    input  logic [1:0]         ext_trig,
    output logic               ev_true
);
    logic cmp_pick;

    // Select one comparator input by index; indices past the last input give false.
    always_comb begin
        cmp_pick = 1'b0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (ev_code[1:0] == 2'(i)) cmp_pick = cmp_match[i];
        end
    end

    // Resolve the event from the reserved code or from the selected input.
    always_comb begin
        if (ev_code == EV_ALWAYS) ev_true = 1'b1;
        else if (ev_code[2])      ev_true = ext_trig[ev_code[0]];
        else                      ev_true = cmp_pick;
    end
endmodule

// File: rtl/trace_enable_ctl.sv
// Module: top of the trace enable start/stop controller.
// Combines the event with the optionally gating start/stop state into a registered
// enable that lags its inputs by one cycle. NUM_CMP is 1 or 4.
module trace_enable_ctl
    import tecfg_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_CMP-1:0] cmp_match,
    input  logic [1:0]         ext_trig,
    output logic               ss_state,
    output logic               trace_en
);
    logic               gate_en;
    logic [CODE_W-1:0]  ev_code;
    logic [NUM_CMP-1:0] start_mask;
    logic [NUM_CMP-1:0] stop_mask;
    logic               ss_next;
    logic               ev_true;

    tecfg_regs #(.NUM_CMP(NUM_CMP), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr[1:0]),
        .wr_data(wr_data), .gate_en(gate_en), .ev_code(ev_code),
        .start_mask(start_mask), .stop_mask(stop_mask)
    );

    tecfg_ss #(.NUM_CMP(NUM_CMP)) u_ss (
        .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match),
        .start_mask(start_mask), .stop_mask(stop_mask),
        .ss_next(ss_next), .ss_q(ss_state)
    );

    tecfg_event #(.NUM_CMP(NUM_CMP)) u_ev (
        .ev_code(ev_code), .cmp_match(cmp_match), .ext_trig(ext_trig),
        .ev_true(ev_true)
    );

    // Register the enable so that it lines up with the new start/stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) trace_en <= 1'b0;
        else        trace_en <= ev_true && (!gate_en || ss_next);
    end
endmodule

// File: rtl/tecfg_chk.sv
// Checker: per-cycle properties of the trace enable start/stop controller.
// Attached to every instance of the top through the bind below.
module tecfg_chk
    import tecfg_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CMP-1:0] cmp_match,
    input logic [NUM_CMP-1:0] start_mask,
    input logic [NUM_CMP-1:0] stop_mask,
    input logic               gate_en,
    input logic [CODE_W-1:0]  ev_code,
    input logic               ss_state,
    input logic               trace_en
);
    logic go_hit;
    logic halt_hit;
    assign go_hit   = |(cmp_match & start_mask);
    assign halt_hit = |(~cmp_match & stop_mask);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!ss_state && !trace_en)); // R1
    AST_START_SET: assert property (@(posedge clk) disable iff (!rst_n) go_hit |=> ss_state); // R2
    AST_START_OVER_STOP: assert property (@(posedge clk) disable iff (!rst_n) (go_hit && halt_hit) |=> ss_state); // R4
    AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!go_hit && halt_hit) |=> !ss_state); // R3
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!go_hit && !halt_hit) |=> $stable(ss_state)); // R5
    AST_GATE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) (trace_en && $past(gate_en)) |-> ss_state); // R6
    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (!rst_n) (ev_code == EV_ALWAYS && !gate_en) |=> trace_en); // R7
endmodule

bind trace_enable_ctl tecfg_chk #(.NUM_CMP(NUM_CMP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .start_mask(start_mask),
    .stop_mask(stop_mask), .gate_en(gate_en), .ev_code(ev_code),
    .ss_state(ss_state), .trace_en(trace_en)
);

// File: tb/tb_trace_enable_ctl.sv
module tb_trace_enable_ctl;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NC-1:0] cmp_match = '0;
    logic [1:0]    ext_trig = '0;
    logic          ss_state;
    logic          trace_en;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the configuration and state.
    logic          m_gate = 1'b0;
    logic [6:0]    m_code = '0;
    logic [NC-1:0] m_sm = '0;
    logic [NC-1:0] m_pm = '0;
    logic          m_ss = 1'b0;

    always #2 clk = ~clk;

    trace_enable_ctl #(.NUM_CMP(NC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_match(cmp_match), .ext_trig(ext_trig),
        .ss_state(ss_state), .trace_en(trace_en)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Advance one edge and compare both outputs with the model.
    task automatic step(input string tag);
        logic go, halt, nx, ev, te;
        go   = |(cmp_match & m_sm);
        halt = |(~cmp_match & m_pm);
        nx   = go ? 1'b1 : (halt ? 1'b0 : m_ss);
        if (m_code == 7'h6F)  ev = 1'b1;
        else if (m_code[2])   ev = ext_trig[m_code[0]];
        else if (int'(m_code[1:0]) < NC) ev = cmp_match[m_code[1:0]];
        else                  ev = 1'b0;
        te = ev && (!m_gate || nx);
        @(posedge clk); #1;
        check(tag, "ss_state", ss_state, nx);
        check(tag, "trace_en", trace_en, te);
        m_ss = nx;
        if (wr_en) begin
            case (wr_addr)
                2'd0: m_gate = wr_data[25];
                2'd1: m_code = wr_data[6:0];
                2'd2: begin m_sm = wr_data[NC-1:0]; m_pm = wr_data[16 +: NC]; end
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset clears outputs even with inputs active.
        cmp_match = '1; ext_trig = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ss_state in reset", ss_state, 1'b0);
        check("R1", "trace_en in reset", trace_en, 1'b0);
        rst_n = 1'b1;
        // R1: zero event code follows cmp_match[0]; masks zero keep state.
        cmp_match = 4'b0001; step("R1");
        cmp_match = 4'b1110; step("R1");

        // R2 R3 R4 R5: sweep every mask pair against every comparator pattern.
        for (int sm = 0; sm < 16; sm++) begin
            for (int pm = 0; pm < 16; pm++) begin
                wr(2'd2, {12'hFFF, 4'(pm), 12'hABC, 4'(sm)}, "R10");
                for (int c = 0; c < 16; c++) begin
                    logic go, halt;
                    cmp_match = 4'(c);
                    ext_trig  = 2'(c) ^ 2'(sm);
                    go   = |(4'(c) & 4'(sm));
                    halt = |(~4'(c) & 4'(pm));
                    step(go && halt ? "R4" : go ? "R2" : halt ? "R3" : "R5");
                end
            end
        end

        // R6 R7 R8: every event code, gate on and off, every input pattern.
        wr(2'd2, 32'h0002_0001, "R10");
        for (int code = 0; code < 128; code++) begin
            wr(2'd1, 32'hFFFF_FF80 | 32'(code), "R10");
            for (int g = 0; g < 2; g++) begin
                wr(2'd0, g[0] ? 32'h0200_0000 : 32'hFDFF_FFFF, "R6");
                for (int v = 0; v < 64; v++) begin
                    cmp_match = 4'(v);
                    ext_trig  = 2'(v >> 4);
                    step(g[0] ? "R6" : (code == 'h6F) ? "R7" : "R8");
                end
            end
        end

        // R10: address 3 writes change nothing.
        wr(2'd1, 32'h0000_0005, "R10");
        wr(2'd0, 32'h0, "R10");
        wr(2'd3, 32'hFFFF_FFFF, "R10");
        for (int v = 0; v < 64; v++) begin
            cmp_match = 4'(v); ext_trig = 2'(v >> 4);
            step("R10");
        end

        // R9: enable changes exactly one edge after the cause.
        wr(2'd2, 32'h0001_0001, "R9");
        wr(2'd1, 32'h0000_006F, "R9");
        wr(2'd0, 32'h0200_0000, "R9");
        cmp_match = 4'b0000; step("R9");
        cmp_match = 4'b0001; #1;
        check("R9", "trace_en before edge", trace_en, 1'b0);
        step("R9");
        cmp_match = 4'b0000; #1;
        check("R9", "trace_en held before edge", trace_en, 1'b1);
        step("R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule